// File: doc/BRIEF.md
# Real-Time Clock with Subsecond Alarm

This block keeps wall time from a 32.768 kHz time base. A single-cycle strobe, `lf_tick`, arrives once per period of the slow clock, synchronous to the system clock `clk`. The count has two parts. A subsecond counter of `SUB_W` bits wraps once per second. A seconds counter of `SEC_W` bits advances each time the subsecond counter wraps.

Software uses a small word-addressed register port. It turns on the oscillator-gate and run bits, loads a starting second, and programs an alarm made of a whole-second value and a subsecond value. It can also mask the alarm interrupt and acknowledge it. When the counter reaches the alarm value on a tick, a sticky raw status bit is set. The interrupt output follows that bit through the mask. If wake is enabled, a one-cycle wake request is also sent to the power controller.

Register map, by word address on `wr_addr`/`rd_addr`:
- 0: control.
- 1: seconds. A write loads the value; a read returns the live count.
- 2: live subseconds, read-only.
- 3: alarm seconds.
- 4: alarm subseconds.
- 5: interrupt mask.
- 6: raw status.
- 7: masked status.

Top module: `rtc_subsec_match`

## Requirements
- R1: After reset, every readable register reads 0, and `irq_o` and `wake_o` are 0.
- R2: While running, each `lf_tick` adds one to the subsecond count (address 2) and leaves seconds unchanged, unless the subsecond count is at its maximum.
- R3: Counting happens only when control bit 0 (oscillator gate) and control bit 1 (run) are both 1. With either bit alone, ticks leave seconds and subseconds unchanged.
- R4: When a running tick finds the subsecond count all ones, the subsecond count goes to 0 and seconds increase by one, wrapping modulo 2^SEC_W.
- R5: A write to address 1 sets seconds to the low SEC_W bits of the data and clears the subsecond count to 0.
- R6: A seconds load in the same cycle as a running tick takes priority. The counter takes the loaded second with subsecond 0 and does not increment.
- R7: Raw status bit 0 (address 6) sets on the tick whose resulting count equals both alarm seconds (address 3) and alarm subseconds (address 4). A mismatch in either field does not set it. A load never sets it.
- R8: `irq_o` and masked status bit 0 (address 7) both equal raw status bit 0 AND mask bit 0 (address 5).
- R9: Raw status stays set until a write to address 6 with data bit 0 = 1. A write there with bit 0 = 0 has no effect. A new match in the same cycle wins over the clear.
- R10: With control bit 2 (wake enable) set, `wake_o` is high for exactly the one cycle after the matching tick edge. With it clear, `wake_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data (combinational by default) |
| irq_o | output | 1 | Masked alarm interrupt |
| wake_o | output | 1 | One-cycle wake request on alarm |

## Verification
The properties assume the following about the inputs:
- `lf_tick` is a clean synchronous enable.
- Reset is held across at least one edge.
- The alarm registers are not rewritten between two adjacent matching ticks, which the one-cycle wake pulse check relies on.

The bench meets these assumptions by driving every input at the falling edge. Ticks and writes are issued as isolated single-cycle strobes, except in the one deliberate case that places a load and a tick in the same cycle. Alarm values change only while no tick is in flight. The bench uses a 4-bit subsecond and 8-bit seconds configuration, so its sweeps cross both the subsecond wrap and the seconds wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [2:0] {
      RA_CTRL = 3'd0,
      RA_SEC  = 3'd1,
      RA_SUB  = 3'd2,
      RA_ASEC = 3'd3,
      RA_ASUB = 3'd4,
      RA_MASK = 3'd5,
      RA_RAW  = 3'd6,
      RA_MIS  = 3'd7
   } rtc_reg_e;

   localparam int CTRL_OSC_BIT  = 0;
   localparam int CTRL_RUN_BIT  = 1;
   localparam int CTRL_WAKE_BIT = 2;
   localparam int MAP_ADDR_W    = 3;

   typedef struct packed {
      logic osc_on;
      logic run_on;
      logic wake_on;
   } rtc_ctrl_t;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3,
   parameter int SEC_W  = 32,
   parameter int SUB_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output rtc_ctrl_t         ctrl_o,
   output logic [SEC_W-1:0]  alarm_sec_o,
   output logic [SUB_W-1:0]  alarm_sub_o,
   output logic              mask_o,
   output logic              load_o,
   output logic [SEC_W-1:0]  load_val_o,
   output logic              clr_o
);
   rtc_ctrl_t        ctrl_q;
   logic [SEC_W-1:0] asec_q;
   logic [SUB_W-1:0] asub_q;
   logic             mask_q;
   logic             hit_ctrl, hit_asec, hit_asub, hit_mask;
   logic             unused_hi;

   assign unused_hi = ^wr_data;

   always_comb begin
      hit_ctrl = wr_en && (wr_addr == ADDR_W'(RA_CTRL));
      hit_asec = wr_en && (wr_addr == ADDR_W'(RA_ASEC));
      hit_asub = wr_en && (wr_addr == ADDR_W'(RA_ASUB));
      hit_mask = wr_en && (wr_addr == ADDR_W'(RA_MASK));
      load_o   = wr_en && (wr_addr == ADDR_W'(RA_SEC));
      clr_o    = wr_en && (wr_addr == ADDR_W'(RA_RAW)) && wr_data[0];
   end

   assign load_val_o = wr_data[SEC_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         asec_q <= '0;
         asub_q <= '0;
         mask_q <= 1'b0;
      end else begin
         if (hit_ctrl) begin
            ctrl_q.osc_on  <= wr_data[CTRL_OSC_BIT];
            ctrl_q.run_on  <= wr_data[CTRL_RUN_BIT];
            ctrl_q.wake_on <= wr_data[CTRL_WAKE_BIT];
         end
         if (hit_asec) asec_q <= wr_data[SEC_W-1:0];
         if (hit_asub) asub_q <= wr_data[SUB_W-1:0];
         if (hit_mask) mask_q <= wr_data[0];
      end
   end

   assign ctrl_o      = ctrl_q;
   assign alarm_sec_o = asec_q;
   assign alarm_sub_o = asub_q;
   assign mask_o      = mask_q;
endmodule

// File: rtl/rtc_count.sv
module rtc_count #(
   parameter int SEC_W = 32,
   parameter int SUB_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             load_i,
   input  logic [SEC_W-1:0] load_val_i,
   output logic [SEC_W-1:0] sec_o,
   output logic [SUB_W-1:0] sub_o,
   output logic             step_o,
   output logic [SEC_W-1:0] sec_nxt_o,
   output logic [SUB_W-1:0] sub_nxt_o
);
   localparam logic [SUB_W-1:0] SUB_TOP = '1;

   logic [SEC_W-1:0] sec_q;
   logic [SUB_W-1:0] sub_q;
   logic             wrap;

   always_comb begin
      step_o    = tick_i && run_i && !load_i;
      wrap      = (sub_q == SUB_TOP);
      sub_nxt_o = sub_q + 1'b1;
      sec_nxt_o = wrap ? sec_q + 1'b1 : sec_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q <= '0;
         sub_q <= '0;
      end else if (load_i) begin
         sec_q <= load_val_i;
         sub_q <= '0;
      end else if (step_o) begin
         sec_q <= sec_nxt_o;
         sub_q <= sub_nxt_o;
      end
   end

   assign sec_o = sec_q;
   assign sub_o = sub_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int SEC_W = 32,
   parameter int SUB_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic [SEC_W-1:0] sec_nxt_i,
   input  logic [SUB_W-1:0] sub_nxt_i,
   input  logic [SEC_W-1:0] alarm_sec_i,
   input  logic [SUB_W-1:0] alarm_sub_i,
   input  logic             clr_i,
   input  logic             mask_i,
   input  logic             wake_en_i,
   output logic             raw_o,
   output logic             irq_o,
   output logic             wake_o
);
   logic raw_q, wake_q, hit;

   always_comb begin
      hit = step_i && (sec_nxt_i == alarm_sec_i) && (sub_nxt_i == alarm_sub_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q  <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         if (hit)        raw_q <= 1'b1;
         else if (clr_i) raw_q <= 1'b0;
         wake_q <= hit && wake_en_i;
      end
   end

   assign raw_o  = raw_q;
   assign irq_o  = raw_q & mask_i;
   assign wake_o = wake_q;
endmodule

// File: rtl/rtc_subsec_match.sv
module rtc_subsec_match
   import rtc_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 3,
   parameter int SEC_W    = 32,
   parameter int SUB_W    = 15,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lf_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o,
   output logic              wake_o
);
   if (SEC_W > DATA_W) begin : g_bad_sec
      $error("SEC_W must not exceed DATA_W");
   end
   if (SUB_W > DATA_W) begin : g_bad_sub
      $error("SUB_W must not exceed DATA_W");
   end
   if (ADDR_W < MAP_ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (SUB_W < 2) begin : g_bad_subw
      $error("SUB_W must be at least 2");
   end

   rtc_ctrl_t        ctrl;
   logic [SEC_W-1:0] alarm_sec, load_val, sec_cnt, sec_nxt;
   logic [SUB_W-1:0] alarm_sub, sub_cnt, sub_nxt;
   logic             mask_q, load_stb, clr_stb, cnt_run, step, raw_q;
   logic [DATA_W-1:0] rd_mux;

   assign cnt_run = ctrl.osc_on && ctrl.run_on;

   rtc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W), .SUB_W(SUB_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl_o(ctrl), .alarm_sec_o(alarm_sec), .alarm_sub_o(alarm_sub), .mask_o(mask_q),
      .load_o(load_stb), .load_val_o(load_val), .clr_o(clr_stb)
   );

   rtc_count #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick_i(lf_tick), .run_i(cnt_run), .load_i(load_stb),
      .load_val_i(load_val), .sec_o(sec_cnt), .sub_o(sub_cnt), .step_o(step),
      .sec_nxt_o(sec_nxt), .sub_nxt_o(sub_nxt)
   );

   rtc_alarm #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_alarm (
      .clk(clk), .rst_n(rst_n), .step_i(step), .sec_nxt_i(sec_nxt), .sub_nxt_i(sub_nxt),
      .alarm_sec_i(alarm_sec), .alarm_sub_i(alarm_sub), .clr_i(clr_stb), .mask_i(mask_q),
      .wake_en_i(ctrl.wake_on), .raw_o(raw_q), .irq_o(irq_o), .wake_o(wake_o)
   );

   always_comb begin
      rd_mux = '0;
      case (rd_addr)
         ADDR_W'(RA_CTRL): begin
            rd_mux[CTRL_OSC_BIT]  = ctrl.osc_on;
            rd_mux[CTRL_RUN_BIT]  = ctrl.run_on;
            rd_mux[CTRL_WAKE_BIT] = ctrl.wake_on;
         end
         ADDR_W'(RA_SEC):  rd_mux[SEC_W-1:0] = sec_cnt;
         ADDR_W'(RA_SUB):  rd_mux[SUB_W-1:0] = sub_cnt;
         ADDR_W'(RA_ASEC): rd_mux[SEC_W-1:0] = alarm_sec;
         ADDR_W'(RA_ASUB): rd_mux[SUB_W-1:0] = alarm_sub;
         ADDR_W'(RA_MASK): rd_mux[0] = mask_q;
         ADDR_W'(RA_RAW):  rd_mux[0] = raw_q;
         ADDR_W'(RA_MIS):  rd_mux[0] = raw_q & mask_q;
         default:          rd_mux = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = rd_mux;
   end
endmodule

// File: rtl/rtc_subsec_match_chk.sv
module rtc_subsec_match_chk #(
   parameter int SEC_W = 32,
   parameter int SUB_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             run,
   input logic             load,
   input logic [SEC_W-1:0] load_val,
   input logic             clr,
   input logic [SEC_W-1:0] sec,
   input logic [SUB_W-1:0] sub,
   input logic             raw,
   input logic             mask,
   input logic             irq,
   input logic             wake
);
   localparam logic [SUB_W-1:0] TOP = '1;

   // R3: nothing moves without run and without a load
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> ($stable(sec) && $stable(sub)));

   // R2: plain step
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load && sub != TOP) |=> (sub == SUB_W'($past(sub) + 1'b1) && $stable(sec)));

   // R4: wrap carries into seconds
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load && sub == TOP) |=> (sub == '0 && sec == SEC_W'($past(sec) + 1'b1)));

   // R5 and R6: load wins and clears subseconds
   a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sub == '0 && sec == $past(load_val)));

   // R9: sticky without a clear
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (raw && !clr) |=> raw);

   // R8: masked raw reaches the interrupt
   a_r8_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (raw && mask && !clr && $stable(mask)) |-> irq);

   // R10: wake only with a fresh match, one cycle wide
   a_r10_wake_src: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (raw && $past(tick)));
   a_r10_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake);
endmodule

bind rtc_subsec_match rtc_subsec_match_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(lf_tick), .run(cnt_run), .load(load_stb),
   .load_val(load_val), .clr(clr_stb), .sec(sec_cnt), .sub(sub_cnt), .raw(raw_q),
   .mask(mask_q), .irq(irq_o), .wake(wake_o)
);

// File: tb/rtc_subsec_match_bench.sv
module rtc_subsec_match_bench;
   localparam int DW = 32, AW = 3, SW = 8, UW = 4;

   logic          clk = 1'b0, rst_n = 1'b0, lf_tick = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0, rd_data;
   logic          irq_o, wake_o;

   int errors = 0, checks = 0;
   bit done = 0;

   logic [SW-1:0] m_sec = '0, m_asec = '0;
   logic [UW-1:0] m_sub = '0, m_asub = '0;
   bit m_osc = 0, m_run = 0, m_wake = 0, m_mask = 0, m_raw = 0;

   rtc_subsec_match #(.DATA_W(DW), .ADDR_W(AW), .SEC_W(SW), .SUB_W(UW)) u_rtc_subsec_match (
      .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_addr = AW'(a);
      #1;
      d = rd_data;
   endtask

   task automatic set_ctrl(input bit o, input bit r, input bit w);
      wr(0, {29'd0, w, r, o});
      m_osc = o; m_run = r; m_wake = w;
   endtask

   task automatic load_sec(input logic [SW-1:0] s);
      wr(1, 32'(s));
      m_sec = s; m_sub = '0;
   endtask

   task automatic tick1();
      bit hit = 0;
      @(negedge clk);
      lf_tick = 1'b1;
      @(negedge clk);
      lf_tick = 1'b0;
      if (m_osc && m_run) begin
         if (m_sub == '1) m_sec = m_sec + 1'b1;
         m_sub = m_sub + 1'b1;
         if (m_sec == m_asec && m_sub == m_asub) begin hit = 1; m_raw = 1; end
      end
      chk(wake_o == (hit && m_wake), "R10 wake", 32'(wake_o), 32'(hit && m_wake));
      chk(irq_o == (m_raw && m_mask), "R8 irq", 32'(irq_o), 32'(m_raw && m_mask));
   endtask

   task automatic chk_count(input string req);
      logic [31:0] v;
      rd(1, v); chk(v == 32'(m_sec), req, v, 32'(m_sec));
      rd(2, v); chk(v == 32'(m_sub), req, v, 32'(m_sub));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(a, v); chk(v == 0, "R1 reset read", v, 0);
      end
      chk(irq_o == 0 && wake_o == 0, "R1 reset outputs", {irq_o, wake_o}, 0);

      // R3 one enable alone holds the count
      set_ctrl(1, 0, 0);
      repeat (3) tick1();
      chk_count("R3 osc only");
      set_ctrl(0, 1, 0);
      repeat (3) tick1();
      chk_count("R3 run only");

      // R2, R4 sweep across subsecond wraps and the seconds wrap
      set_ctrl(1, 1, 0);
      load_sec(8'd253);
      for (int i = 0; i < 56; i++) begin
         tick1();
         chk_count("R2 R4 sweep");
      end
      wr(6, 32'd1); m_raw = 0;
      rd(6, v); chk(v == 0, "R9 clear", v, 0);

      // R5 load clears subseconds
      repeat (5) tick1();
      load_sec(8'd7);
      chk_count("R5 load");

      // R6 load and tick together
      repeat (3) tick1();
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(1); wr_data = 32'd20; lf_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; lf_tick = 1'b0;
      m_sec = 8'd20; m_sub = '0;
      chk_count("R6 load wins");

      // R7, R8 sweep of alarm values with mask off, then on
      for (int mk = 0; mk < 2; mk++) begin
         wr(5, 32'(mk)); m_mask = bit'(mk);
         for (int s = 0; s < 16; s += 5) begin
            wr(3, 32'd4); m_asec = 8'd4;
            wr(4, 32'(s)); m_asub = UW'(s);
            load_sec(8'd3);
            wr(6, 32'd1); m_raw = 0;
            for (int i = 0; i < 40; i++) tick1();
            rd(6, v); chk(v == 32'(m_raw), "R7 raw", v, 32'(m_raw));
            rd(7, v); chk(v == 32'(m_raw && m_mask), "R8 masked", v, 32'(m_raw && m_mask));
         end
      end

      // R7 seconds mismatch never sets
      wr(3, 32'd99); m_asec = 8'd99;
      load_sec(8'd5);
      wr(6, 32'd1); m_raw = 0;
      repeat (40) tick1();
      rd(6, v); chk(v == 0, "R7 mismatch", v, 0);

      // R9 sticky, write 0 ignored, write 1 clears
      wr(3, 32'd5); m_asec = 8'd5; wr(4, 32'd2); m_asub = 4'd2;
      load_sec(8'd5);
      repeat (3) tick1();
      rd(6, v); chk(v == 1, "R9 set", v, 1);
      repeat (4) tick1();
      wr(6, 32'd0);
      rd(6, v); chk(v == 1, "R9 write0 ignored", v, 1);
      chk(irq_o == 1, "R9 irq held", 32'(irq_o), 1);
      wr(6, 32'd1); m_raw = 0;
      rd(6, v); chk(v == 0, "R9 w1c", v, 0);
      chk(irq_o == 0, "R9 irq cleared", 32'(irq_o), 0);

      // R10 wake pulse
      set_ctrl(1, 1, 1);
      load_sec(8'd5);
      repeat (4) tick1();
      chk(wake_o == 0, "R10 pulse end", 32'(wake_o), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule